// File: doc/BRIEF.md
# Page Table Walker

This block turns a virtual address into a physical address by reading a chain of 64-bit translation entries from memory, one entry per level. It has two modes. In the narrow mode a 32-bit virtual address goes through three levels, and the first level is a small table of four entries. In the wide mode a 48-bit virtual address, carried in a 64-bit word, goes through four levels. The walk stops early when an entry maps a large page. It also stops on any entry that is not present. In the wide mode a malformed upper address half makes the block fault before it reads anything.

A client raises `req_valid` while `busy` is low. The block then captures the address, the mode and the root table base. It issues one memory read at a time and waits for each response. The result or the fault is presented with a single-cycle `done` pulse. Only one walk runs at a time.

Top module: `ptw_walker`

## Requirements
- R1: A request is taken in a cycle where `req_valid` is high and `busy` is low. `busy` is high from the next cycle up to and including the `done` cycle. `req_valid` has no effect while `busy` is high, and the walk in progress returns its own result.
- R2: In narrow mode (`req_long`=0), the first read goes to `root_base` with its low 5 bits cleared, plus 8 × vaddr[31:30]. The directory and page-table indexes are vaddr[29:21] and vaddr[20:12]. The virtual address, mode and root are sampled only in the accept cycle.
- R3: In wide mode (`req_long`=1), the first read goes to `root_base` with its low 12 bits cleared, plus 8 × vaddr[47:39]. The later levels use vaddr[38:30], vaddr[29:21] and vaddr[20:12] in that order. Each next table base is the previous entry's bits 51:12 followed by twelve zero bits.
- R4: A walk that ends at a page-table entry gives `paddr` = {entry[51:12], vaddr[11:0]} and `page_size` = 0. The page-size codes are 0 for 4KB, 1 for 2MB and 2 for 1GB.
- R5: If a directory-level entry has bit 7 set, the walk stops with no further read. It gives `paddr` = {entry[51:21], vaddr[20:0]} and `page_size` = 1. This holds in both modes.
- R6: In wide mode, if the directory-pointer entry (the second level read) has bit 7 set, the walk stops. It gives `paddr` = {entry[51:30], vaddr[29:0]} and `page_size` = 2.
- R7: Bit 7 has no effect in the first-level entry of either mode, in the four-entry level of narrow mode, and in page-table entries.
- R8: In wide mode, a virtual address whose bits 63:48 do not all equal bit 47 faults with `fault_level` = 0. No memory read is made, and `done` rises in the cycle after the accept.
- R9: An entry with bit 0 clear ends the walk with `fault`=1 and no further read. `fault_level` gives the level of that entry: 4 is the wide-mode top, 3 the pointer level, 2 the directory and 1 the page table. On any fault, `paddr` and `page_size` read zero.
- R10: `done` lasts exactly one cycle, and `busy` is low in the cycle after it. Out of reset `busy`, `done` and `mem_req` are low. `mem_req` pulses once per level read.
- R11: In narrow mode, vaddr[63:32] is ignored and no canonical check is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 64 | Virtual address |
| req_long | input | 1 | 1 = four-level 48-bit mode, 0 = three-level 32-bit mode |
| root_base | input | PA_W | Physical base of the top table |
| busy | output | 1 | Walk in progress; new requests are not taken |
| mem_req | output | 1 | One-cycle entry read request |
| mem_addr | output | PA_W | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Entry data valid |
| mem_resp_data | input | 64 | Returned entry |
| done | output | 1 | Result valid for one cycle |
| fault | output | 1 | Walk failed |
| fault_level | output | 3 | Level of the fault, 0 for a non-canonical address |
| paddr | output | PA_W | Translated physical address |
| page_size | output | 2 | 0 = 4KB, 1 = 2MB, 2 = 1GB |

## Verification
The hardest case to reach is a request that arrives in the middle of a walk. It must be dropped even though the memory response to the earlier walk is still pending. The bench raises a second request for a different, fully mapped address two cycles into a slow three-read walk. It then expects the original mapping and the original read sequence. Early stops are reached by placing bit 7 in the entry tables at chosen levels. Those levels include the ones where the bit must be ignored. Memory latency varies from walk to walk, so each response lands at a different distance from its request.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int PA_W = 52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [63:0]     req_vaddr,
  input  logic            req_long,
  input  logic [PA_W-1:0] root_base,
  output logic            busy,
  output logic            mem_req,
  output logic [PA_W-1:0] mem_addr,
  input  logic            mem_resp_valid,
  input  logic [63:0]     mem_resp_data,
  output logic            done,
  output logic            fault,
  output logic [2:0]      fault_level,
  output logic [PA_W-1:0] paddr,
  output logic [1:0]      page_size
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} state_t;

  state_t          state;
  logic [2:0]      lvl;
  logic [47:0]     va_q;
  logic            long_q;
  logic [PA_W-1:0] tbl_q;
  logic [8:0]      idx;
  logic            canon, present, ps;
  logic            unused_bits;

  assign canon   = (&req_vaddr[63:47]) | ~(|req_vaddr[63:47]);
  assign present = mem_resp_data[0];
  assign ps      = mem_resp_data[7];
  assign busy    = state != S_IDLE;
  assign done    = state == S_DONE;
  assign mem_req = state == S_ISSUE;
  assign unused_bits = ^{mem_resp_data[63:PA_W], mem_resp_data[11:8],
                         mem_resp_data[6:1], root_base[4:0]};

  always_comb begin
    case (lvl)
      3'd4:    idx = va_q[47:39];
      3'd3:    idx = long_q ? va_q[38:30] : {7'd0, va_q[31:30]};
      3'd2:    idx = va_q[29:21];
      default: idx = va_q[20:12];
    endcase
  end

  assign mem_addr = tbl_q + PA_W'({idx, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      lvl         <= '0;
      va_q        <= '0;
      long_q      <= 1'b0;
      tbl_q       <= '0;
      fault       <= 1'b0;
      fault_level <= '0;
      paddr       <= '0;
      page_size   <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          va_q        <= req_vaddr[47:0];
          long_q      <= req_long;
          fault       <= 1'b0;
          fault_level <= '0;
          paddr       <= '0;
          page_size   <= '0;
          if (req_long && !canon) begin
            fault <= 1'b1;
            state <= S_DONE;
          end else begin
            lvl   <= req_long ? 3'd4 : 3'd3;
            tbl_q <= req_long ? {root_base[PA_W-1:12], 12'd0}
                              : {root_base[PA_W-1:5], 5'd0};
            state <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_WAIT;
        S_WAIT: if (mem_resp_valid) begin
          if (!present) begin
            fault       <= 1'b1;
            fault_level <= lvl;
            state       <= S_DONE;
          end else if (lvl == 3'd1) begin
            paddr <= {mem_resp_data[PA_W-1:12], va_q[11:0]};
            state <= S_DONE;
          end else if (lvl == 3'd2 && ps) begin
            paddr     <= {mem_resp_data[PA_W-1:21], va_q[20:0]};
            page_size <= 2'd1;
            state     <= S_DONE;
          end else if (lvl == 3'd3 && long_q && ps) begin
            paddr     <= {mem_resp_data[PA_W-1:30], va_q[29:0]};
            page_size <= 2'd2;
            state     <= S_DONE;
          end else begin
            tbl_q <= {mem_resp_data[PA_W-1:12], 12'd0};
            lvl   <= lvl - 3'd1;
            state <= S_ISSUE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy) |=> busy);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_size_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> page_size != 2'd3);

  p_noncanon_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_long && req_vaddr[63:48] != {16{req_vaddr[47]}})
      |=> (done && fault && fault_level == 3'd0 && !mem_req));

  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (paddr == '0 && page_size == 2'd0));

endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
  localparam int PA_W = 52;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_long = 1'b0;
  logic [63:0] req_vaddr = '0;
  logic [PA_W-1:0] root_base = '0;
  logic busy, mem_req, done, fault;
  logic [PA_W-1:0] mem_addr, paddr;
  logic mem_resp_valid = 1'b0;
  logic [63:0] mem_resp_data = '0;
  logic [2:0] fault_level;
  logic [1:0] page_size;

  always #2.5 clk = ~clk;

  ptw_walker #(.PA_W(PA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_long(req_long), .root_base(root_base), .busy(busy), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
    .done(done), .fault(fault), .fault_level(fault_level), .paddr(paddr),
    .page_size(page_size));

  logic [63:0] mem [logic [51:0]];
  logic [51:0] expq [$];
  int nchk = 0, nfail = 0;
  int lat_cfg = 0, cnt = 0;
  string cur_req = "";
  logic [51:0] rd_addr;

  localparam logic [51:0] ROOT64 = 52'h1000;
  localparam logic [51:0] ROOT32 = 52'hA3;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic model(input logic [63:0] va, input logic lng, input logic [51:0] root,
                       output logic [51:0] ep, output logic [1:0] es,
                       output logic ef, output logic [2:0] el);
    logic [51:0] base, a;
    logic [63:0] e;
    int lv, ix;
    ep = '0; es = '0; ef = 1'b0; el = '0;
    if (lng && va[63:48] != {16{va[47]}}) begin ef = 1'b1; return; end
    lv = lng ? 4 : 3;
    base = lng ? {root[51:12], 12'd0} : {root[51:5], 5'd0};
    forever begin
      case (lv)
        4: ix = int'(va[47:39]);
        3: ix = lng ? int'(va[38:30]) : int'(va[31:30]);
        2: ix = int'(va[29:21]);
        default: ix = int'(va[20:12]);
      endcase
      a = base + 52'(ix * 8);
      expq.push_back(a);
      e = rd(a);
      if (!e[0]) begin ef = 1'b1; el = 3'(lv); return; end
      if (lv == 1) begin ep = {e[51:12], va[11:0]}; es = 2'd0; return; end
      if (lv == 2 && e[7]) begin ep = {e[51:21], va[20:0]}; es = 2'd1; return; end
      if (lv == 3 && lng && e[7]) begin ep = {e[51:30], va[29:0]}; es = 2'd2; return; end
      base = {e[51:12], 12'd0};
      lv--;
    end
  endtask

  always @(negedge clk) begin
    mem_resp_valid = 1'b0;
    if (cnt > 0) begin
      cnt--;
      if (cnt == 0) begin
        mem_resp_valid = 1'b1;
        mem_resp_data  = rd(rd_addr);
      end
    end
    if (mem_req) begin
      if (expq.size() == 0) chk(1'b0, {cur_req, " unexpected read"}, 64'(mem_addr), 64'h0);
      else begin
        logic [51:0] ea;
        ea = expq.pop_front();
        chk(mem_addr == ea, {cur_req, " read address"}, 64'(mem_addr), 64'(ea));
      end
      rd_addr = mem_addr;
      cnt = lat_cfg + 1;
    end
  end

  task automatic do_walk(input logic [63:0] va, input logic lng, input int lat,
                         input string rq, input bit poke);
    logic [51:0] ep; logic [1:0] es; logic ef; logic [2:0] el;
    int n;
    expq.delete();
    model(va, lng, lng ? ROOT64 : ROOT32, ep, es, ef, el);
    lat_cfg = lat;
    cur_req = rq;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_long = lng; root_base = lng ? ROOT64 : ROOT32;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = '1; req_long = ~lng; root_base = '0;
    chk(busy == 1'b1, "R1 busy after accept", 64'(busy), 64'h1);
    if (poke) begin
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = 64'h0000_1234_5678_9abc; req_long = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
    end
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done == 1'b1, {rq, " done seen"}, 64'(done), 64'h1);
    chk(fault == ef, {rq, " fault"}, 64'(fault), 64'(ef));
    chk(fault_level == el, {rq, " fault_level"}, 64'(fault_level), 64'(el));
    chk(paddr == ep, {rq, " paddr"}, 64'(paddr), 64'(ep));
    chk(page_size == es, {rq, " page_size"}, 64'(page_size), 64'(es));
    chk(expq.size() == 0, {rq, " all reads issued"}, 64'(expq.size()), 64'h0);
    @(negedge clk);
    chk(!done && !busy, "R10 done single cycle, idle after", 64'({done, busy}), 64'h0);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [63:0] va;
    va = 64'h0000_1234_5678_9abc;
    mem[52'h1000 + 52'(va[47:39]) * 8] = 64'h2081;
    mem[52'h2000 + 52'(va[38:30]) * 8] = 64'h3001;
    mem[52'h3000 + 52'(va[29:21]) * 8] = 64'h4001;
    mem[52'h4000 + 52'(va[20:12]) * 8] = 64'h000A_BCDE_F081;
    va = 64'h0000_2000_4060_1234;
    mem[52'h1000 + 52'(va[47:39]) * 8] = 64'h5001;
    mem[52'h5000 + 52'(va[38:30]) * 8] = 64'h6001;
    mem[52'h6000 + 52'(va[29:21]) * 8] = 64'h0000_0012_3460_0081;
    va = 64'h0000_3000_8765_4321;
    mem[52'h1000 + 52'(va[47:39]) * 8] = 64'h7001;
    mem[52'h7000 + 52'(va[38:30]) * 8] = 64'h0000_00AB_C000_0081;
    va = 64'h0000_4000_0000_0000;
    mem[52'h1000 + 52'(va[47:39]) * 8] = 64'h8001;
    mem[52'h8000 + 52'(va[38:30]) * 8] = 64'h9001;
    va = 64'hDEAD_BEEF_C0A0_5123;
    mem[52'hA0 + 52'(va[31:30]) * 8] = 64'hB081;
    mem[52'hB000 + 52'(va[29:21]) * 8] = 64'hC001;
    mem[52'hC000 + 52'(va[20:12]) * 8] = 64'h0007_7777_7081;
    va = 64'h0000_0000_4060_0ABC;
    mem[52'hA0 + 52'(va[31:30]) * 8] = 64'hD001;
    mem[52'hD000 + 52'(va[29:21]) * 8] = 64'h0000_0055_5540_0081;
    va = 64'h0000_0000_8000_0000;
    mem[52'hA0 + 52'(va[31:30]) * 8] = 64'hE001;
    mem[52'hE000 + 52'(va[29:21]) * 8] = 64'hF001;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R10 reset state", 64'({busy, done, mem_req}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_req, "R10 idle after reset", 64'({busy, done, mem_req}), 64'h0);

    do_walk(64'h0000_1234_5678_9abc, 1'b1, 0, "R3 R4 R7 wide 4KB", 1'b0);
    do_walk(64'h0000_2000_4060_1234, 1'b1, 3, "R1 R5 wide 2MB with request while busy", 1'b1);
    do_walk(64'h0000_3000_8765_4321, 1'b1, 1, "R6 wide 1GB", 1'b0);
    do_walk(64'h8000_1234_0000_0000, 1'b1, 0, "R8 non-canonical", 1'b0);
    do_walk(64'hFFFF_8000_0000_1000, 1'b1, 2, "R9 upper-half canonical, top missing", 1'b0);
    do_walk(64'h0000_4000_0000_0000, 1'b1, 0, "R9 directory missing", 1'b0);
    do_walk(64'hDEAD_BEEF_C0A0_5123, 1'b0, 1, "R2 R7 R11 narrow 4KB", 1'b0);
    do_walk(64'h0000_0000_4060_0ABC, 1'b0, 0, "R5 narrow 2MB", 1'b0);
    do_walk(64'h0000_0000_8000_0000, 1'b0, 2, "R9 narrow page table missing", 1'b0);
    do_walk(64'h0000_0000_0000_1000, 1'b0, 0, "R9 narrow top entry missing", 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule